// File: doc/BRIEF.md
# Two-Source Prioritized Interrupt Controller

This block gathers interrupt events from two origins: a level pin from outside the chip and a one-clock overflow pulse from a timing divider. Each origin latches into its own request flag. The flags are gated by per-source mask inputs and by a global enable flag held inside the block. When a qualified request is present, the block raises a one-clock INT pulse toward a small processor core and presents a fixed 12-bit vector address for the chosen source. The pulse is only raised on an instruction-cycle boundary.

The core supplies an instruction-cycle strobe and a busy flag, which it holds while a two-cycle instruction or a run of skipped instructions is still in progress. It also supplies a return-from-interrupt strobe, strobes that set and clear the global enable, and test-and-clear strobes that let software poll a flag and clear it. A standby-inhibit output tells the power sequencer that standby entry must not happen, because an enabled source is already active. The program counter, the return stack and the clock gating live elsewhere.

Top module: `dual_irq_ctrl`

## Requirements
- R1: The pin request flag (`flag_ext`) is set by a low-to-high transition of `ext_pin` after `PIN_SYNC` synchronizer stages. A pin that stays high or falls does not set it.
- R2: The divider request flag (`flag_div`) is set by any clock cycle in which `div_ovf` is high.
- R3: A source reaches the INT logic only while its own mask input (`mask_ext` for the pin, `mask_div` for the divider) is 1. A flagged source with a mask of 0 never produces `int_pulse`.
- R4: No interrupt is issued while the global enable `ien` is 0. `ien_set` and `reti_stb` set it. `ien_clr` clears it and wins over a set in the same cycle. Every acceptance clears it.
- R5: When both sources are qualified, the pin source is taken first. The vector is page 2 step 0 (0x080) for the pin and page 2 step 4 (0x084) for the divider, with the page in bits 11:6 and the step in bits 5:0.
- R6: A request first needs one instruction-cycle boundary to be seen. It is accepted at the next boundary, so `int_pulse` is high for exactly the one clock after the second `cyc_stb` sample following the flag set.
- R7: Acceptance clears the accepted source's flag. The other flag stays pending.
- R8: After `reti_stb`, the first following `cyc_stb` boundary never accepts a request, so one instruction runs before a pending request is taken.
- R9: A boundary at which `busy` is 1 does not accept. Acceptance happens at the first later boundary with `busy` at 0.
- R10: `sb_inhibit` is 1 exactly when (`mask_ext` is 1 and the synchronized pin is high) or (`mask_div` is 1 and `flag_div` is 1).
- R11: `tc_ext`/`tc_div` clear their flag on the next clock. An event in the same cycle as the clear leaves the flag set.
- R12: Reset (`rst_n` low) clears both flags, the global enable, `int_pulse` and `vec_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin level |
| div_ovf | input | 1 | Divider overflow pulse |
| cyc_stb | input | 1 | Instruction-cycle boundary strobe |
| busy | input | 1 | Two-cycle instruction or skip run in progress |
| reti_stb | input | 1 | Return-from-interrupt executed |
| ien_set | input | 1 | Set global enable |
| ien_clr | input | 1 | Clear global enable |
| mask_ext | input | 1 | Pin source mask, 1 = allowed |
| mask_div | input | 1 | Divider source mask, 1 = allowed |
| tc_ext | input | 1 | Test-and-clear strobe, pin flag |
| tc_div | input | 1 | Test-and-clear strobe, divider flag |
| flag_ext | output | 1 | Pin request flag |
| flag_div | output | 1 | Divider request flag |
| ien | output | 1 | Global enable state |
| int_pulse | output | 1 | One-clock interrupt request to the core |
| vec_addr | output | ADDR_W | Vector of the last accepted source |
| sb_inhibit | output | 1 | Standby entry must be refused |

## Verification
If the seen-stage or return-hold register is wrong, the INT pulse appears one boundary early or late. The bench detects this at the very next `cyc_stb` sample, because it checks `int_pulse` at the negative edge after every boundary. A flag that clears the wrong source, or a priority error, shows up in `vec_addr` and in the `flag_ext`/`flag_div` outputs one clock after acceptance. A corrupted enable shows up as a missing or extra pulse, counted across the sweep over all mask, enable and event combinations.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int IRQ_NSRC = 2;
   typedef enum int {
      SRC_EXT = 0,
      SRC_DIV = 1
   } irq_src_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 0) $error("irq_sync: STAGES must be non-negative");
   end

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/irq_req_flag.sv
module irq_req_flag #(
   parameter bit EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   input  logic clr,
   output logic flag
);
   logic evt;
   logic flag_q;

   generate
      if (EDGE) begin : g_edge
         logic d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) d_q <= 1'b0;
            else        d_q <= d;
         end
         assign evt = d & ~d_q;
      end else begin : g_pulse
         assign evt = d;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (evt) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
   end

   assign flag = flag_q;

   AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(evt)); // R1, R2

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt) |=> !flag_q); // R11
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N = 2
) (
   input  logic [N-1:0] qual,
   output logic [N-1:0] grant,
   output logic         any
);
   initial begin
      if (N < 1) $error("irq_prio_pick: N must be at least 1");
   end

   always_comb begin
      grant = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (qual[i]) grant = N'(1) << i;
      end
   end

   assign any = |qual;
endmodule

// File: rtl/irq_issue_seq.sv
module irq_issue_seq #(
   parameter int N      = 2,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_stb,
   input  logic              busy,
   input  logic              reti_stb,
   input  logic              ien_set,
   input  logic              ien_clr,
   input  logic              any_req,
   input  logic [N-1:0]      grant,
   input  logic [ADDR_W-1:0] grant_vec,
   output logic [N-1:0]      ack,
   output logic              int_pulse,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              ien
);
   logic seen_q;
   logic hold_q;
   logic ien_q;
   logic int_q;
   logic [ADDR_W-1:0] vec_q;
   logic accept;

   assign accept = cyc_stb & seen_q & any_req & ien_q & ~busy & ~hold_q;
   assign ack    = accept ? grant : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         hold_q <= 1'b0;
         ien_q  <= 1'b0;
         int_q  <= 1'b0;
         vec_q  <= '0;
      end else begin
         if (cyc_stb) seen_q <= any_req;
         if (reti_stb)     hold_q <= 1'b1;
         else if (cyc_stb) hold_q <= 1'b0;
         if (accept || ien_clr)        ien_q <= 1'b0;
         else if (ien_set || reti_stb) ien_q <= 1'b1;
         int_q <= accept;
         if (accept) vec_q <= grant_vec;
      end
   end

   assign int_pulse = int_q;
   assign vec_addr  = vec_q;
   assign ien       = ien_q;

   AST_INT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      int_q |=> !int_q); // R6

   AST_INT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      int_q |-> ($past(ien_q) && !ien_q)); // R4

   AST_INT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      int_q |-> ($past(cyc_stb) && !$past(busy))); // R9

   AST_RET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      int_q |-> !$past(hold_q)); // R8

   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack)); // R7
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
   import irq_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int STEP_W   = 6,
   parameter int VEC_PAGE = 2,
   parameter int EXT_STEP = 0,
   parameter int DIV_STEP = 4,
   parameter int PIN_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_pin,
   input  logic              div_ovf,
   input  logic              cyc_stb,
   input  logic              busy,
   input  logic              reti_stb,
   input  logic              ien_set,
   input  logic              ien_clr,
   input  logic              mask_ext,
   input  logic              mask_div,
   input  logic              tc_ext,
   input  logic              tc_div,
   output logic              flag_ext,
   output logic              flag_div,
   output logic              ien,
   output logic              int_pulse,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              sb_inhibit
);
   localparam int PAGE_W = ADDR_W - STEP_W;

   initial begin
      if (STEP_W < 1 || PAGE_W < 1) $error("dual_irq_ctrl: bad address split");
      if (VEC_PAGE >= (1 << PAGE_W)) $error("dual_irq_ctrl: VEC_PAGE out of range");
      if (EXT_STEP >= (1 << STEP_W) || DIV_STEP >= (1 << STEP_W))
         $error("dual_irq_ctrl: step out of range");
      if (EXT_STEP == DIV_STEP) $error("dual_irq_ctrl: vectors collide");
   end

   logic                pin_lvl;
   logic [IRQ_NSRC-1:0] flags;
   logic [IRQ_NSRC-1:0] masks;
   logic [IRQ_NSRC-1:0] tcs;
   logic [IRQ_NSRC-1:0] srcs;
   logic [IRQ_NSRC-1:0] qual;
   logic [IRQ_NSRC-1:0] grant;
   logic [IRQ_NSRC-1:0] ack;
   logic                any_req;
   logic [ADDR_W-1:0]   vec_tbl [IRQ_NSRC];
   logic [ADDR_W-1:0]   grant_vec;

   irq_sync #(.STAGES(PIN_SYNC)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(pin_lvl)
   );

   assign srcs[SRC_EXT]    = pin_lvl;
   assign srcs[SRC_DIV]    = div_ovf;
   assign masks[SRC_EXT]   = mask_ext;
   assign masks[SRC_DIV]   = mask_div;
   assign tcs[SRC_EXT]     = tc_ext;
   assign tcs[SRC_DIV]     = tc_div;
   assign vec_tbl[SRC_EXT] = {PAGE_W'(VEC_PAGE), STEP_W'(EXT_STEP)};
   assign vec_tbl[SRC_DIV] = {PAGE_W'(VEC_PAGE), STEP_W'(DIV_STEP)};

   generate
      for (genvar s = 0; s < IRQ_NSRC; s++) begin : g_src
         irq_req_flag #(.EDGE(s == SRC_EXT)) u_flag (
            .clk(clk), .rst_n(rst_n), .d(srcs[s]),
            .clr(tcs[s] | ack[s]), .flag(flags[s])
         );
         assign qual[s] = flags[s] & masks[s];
      end
   endgenerate

   irq_prio_pick #(.N(IRQ_NSRC)) u_pick (
      .qual(qual), .grant(grant), .any(any_req)
   );

   always_comb begin
      grant_vec = '0;
      for (int i = 0; i < IRQ_NSRC; i++) begin
         if (grant[i]) grant_vec = vec_tbl[i];
      end
   end

   irq_issue_seq #(.N(IRQ_NSRC), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .busy(busy),
      .reti_stb(reti_stb), .ien_set(ien_set), .ien_clr(ien_clr),
      .any_req(any_req), .grant(grant), .grant_vec(grant_vec),
      .ack(ack), .int_pulse(int_pulse), .vec_addr(vec_addr), .ien(ien)
   );

   assign flag_ext   = flags[SRC_EXT];
   assign flag_div   = flags[SRC_DIV];
   assign sb_inhibit = (mask_ext & pin_lvl) | (mask_div & flags[SRC_DIV]);

   AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      int_pulse |-> $past(|qual)); // R3

   AST_PIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (int_pulse && $past(qual[SRC_EXT])) |-> (vec_addr == vec_tbl[SRC_EXT])); // R5
endmodule

// File: tb/sim_dual_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dual_irq_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_pin = 0, div_ovf = 0, cyc_stb = 0, busy = 0, reti_stb = 0;
   logic ien_set = 0, ien_clr = 0, mask_ext = 0, mask_div = 0, tc_ext = 0, tc_div = 0;
   logic flag_ext, flag_div, ien, int_pulse, sb_inhibit;
   logic [11:0] vec_addr;
   int checks = 0;
   int errors = 0;
   int pulses = 0;

   always #10 clk = ~clk;

   dual_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .div_ovf(div_ovf),
      .cyc_stb(cyc_stb), .busy(busy), .reti_stb(reti_stb), .ien_set(ien_set),
      .ien_clr(ien_clr), .mask_ext(mask_ext), .mask_div(mask_div),
      .tc_ext(tc_ext), .tc_div(tc_div), .flag_ext(flag_ext), .flag_div(flag_div),
      .ien(ien), .int_pulse(int_pulse), .vec_addr(vec_addr), .sb_inhibit(sb_inhibit)
   );

   always @(negedge clk) if (int_pulse === 1'b1) pulses++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      {ext_pin, div_ovf, cyc_stb, busy, reti_stb, ien_set, ien_clr} = '0;
      {mask_ext, mask_div, tc_ext, tc_div} = '0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic pulse_sig(ref logic s);
      s = 1'b1;
      step(1);
      s = 1'b0;
   endtask

   task automatic boundary();
      cyc_stb = 1'b1;
      step(1);
      cyc_stb = 1'b0;
   endtask

   task automatic fire_ext();
      ext_pin = 1'b1;
      step(4);
   endtask

   initial begin
      #3_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R12: reset state
      chk("R12 flag_ext", flag_ext, 0);
      chk("R12 flag_div", flag_div, 0);
      chk("R12 ien", ien, 0);
      chk("R12 int", int_pulse, 0);
      chk("R12 vec", vec_addr, 0);

      // Sweep: masks x enable x events (R3 R4 R5 R6)
      for (int me = 0; me < 2; me++)
         for (int md = 0; md < 2; md++)
            for (int en = 0; en < 2; en++)
               for (int ev = 1; ev < 4; ev++) begin
                  logic qe, qd, exp_int;
                  logic [11:0] exp_vec;
                  do_reset();
                  mask_ext = me[0];
                  mask_div = md[0];
                  if (en != 0) pulse_sig(ien_set);
                  if (ev[0]) fire_ext();
                  if (ev[1]) pulse_sig(div_ovf);
                  qe = ev[0] & me[0];
                  qd = ev[1] & md[0];
                  exp_int = (en != 0) && (qe || qd);
                  exp_vec = !exp_int ? 12'h000 : (qe ? 12'h080 : 12'h084);
                  pulses = 0;
                  boundary();
                  chk("R6 no int at first boundary", int_pulse, 0);
                  boundary();
                  chk("R3 R4 int at second boundary", int_pulse, exp_int);
                  step(2);
                  chk("R6 single pulse count", pulses, exp_int);
                  chk("R5 vector", vec_addr, exp_vec);
                  if (exp_int) chk("R4 ien cleared on accept", ien, 0);
                  ext_pin = 1'b0;
               end

      // R1: held-high and falling pin do not set flag
      do_reset();
      fire_ext();
      chk("R1 rising edge sets", flag_ext, 1);
      pulse_sig(tc_ext);
      step(4);
      chk("R1 steady high no set", flag_ext, 0);
      ext_pin = 1'b0;
      step(4);
      chk("R1 falling no set", flag_ext, 0);

      // R2 and R11
      pulse_sig(div_ovf);
      chk("R2 div flag set", flag_div, 1);
      pulse_sig(tc_div);
      chk("R11 test-and-clear", flag_div, 0);
      div_ovf = 1'b1; tc_div = 1'b1;
      step(1);
      div_ovf = 1'b0; tc_div = 1'b0;
      chk("R11 event beats clear", flag_div, 1);

      // R10: standby inhibit
      do_reset();
      mask_ext = 1'b1;
      ext_pin = 1'b1;
      step(3);
      chk("R10 pin high masked in", sb_inhibit, 1);
      mask_ext = 1'b0;
      step(1);
      chk("R10 pin mask out", sb_inhibit, 0);
      ext_pin = 1'b0;
      mask_div = 1'b1;
      step(3);
      chk("R10 idle", sb_inhibit, 0);
      pulse_sig(div_ovf);
      chk("R10 div flag masked in", sb_inhibit, 1);
      mask_div = 1'b0;
      step(1);
      chk("R10 div mask out", sb_inhibit, 0);

      // R7 R8: both pending, then return
      do_reset();
      mask_ext = 1'b1; mask_div = 1'b1;
      pulse_sig(ien_set);
      fire_ext();
      pulse_sig(div_ovf);
      boundary();
      boundary();
      chk("R5 pin first", int_pulse, 1);
      chk("R5 pin vector", vec_addr, 12'h080);
      step(1);
      chk("R7 accepted flag cleared", flag_ext, 0);
      chk("R7 other flag pending", flag_div, 1);
      boundary();
      chk("R4 no int while disabled", int_pulse, 0);
      pulse_sig(reti_stb);
      chk("R8 reti sets ien", ien, 1);
      boundary();
      chk("R8 first boundary after return skipped", int_pulse, 0);
      boundary();
      chk("R8 divider taken next", int_pulse, 1);
      chk("R5 div vector", vec_addr, 12'h084);
      ext_pin = 1'b0;

      // R9: busy defers
      do_reset();
      mask_div = 1'b1;
      pulse_sig(ien_set);
      pulse_sig(div_ovf);
      boundary();
      busy = 1'b1;
      boundary();
      chk("R9 deferred while busy", int_pulse, 0);
      busy = 1'b0;
      step(1);
      boundary();
      chk("R9 accepted after busy", int_pulse, 1);

      // R4: clear wins over set
      do_reset();
      mask_div = 1'b1;
      ien_set = 1'b1; ien_clr = 1'b1;
      step(1);
      ien_set = 1'b0; ien_clr = 1'b0;
      chk("R4 clear beats set", ien, 0);
      pulse_sig(div_ovf);
      boundary();
      boundary();
      chk("R4 no int when disabled", int_pulse, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule